// File: doc/BRIEF.md
# I2C Slave Port with Software Clock Stretching

This block is a byte-wide I2C target with a small register interface for the host. The host sets an own address, an enable bit, a clock-release bit and a 4-bit mode code. The port then watches the bus for a START condition and shifts in the address byte. If the 7-bit address matches, the port acknowledges it and moves data one byte at a time through a single data buffer, in the direction that the read/write bit selects. Both bus lines are open-drain: the block never drives a line high. It only asserts a pull-low enable, and the bus model outside the block resolves the wired-AND.

After the acknowledge clock of every handled byte, the address byte included, the port clears its release bit and holds SCL low. Software reads or loads the buffer during this time and then writes the release bit back to 1. Two sticky error flags record buffer misuse, and each flag is active only in the direction where it applies. The receive-overflow flag is set when a byte arrives while the buffer is still full. The write-collision flag is set when the host writes the buffer while a byte is still shifting out. A one-cycle interrupt pulse marks each completed byte. In the event mode, the same pulse also marks START and STOP conditions.

Top module: `i2cs_port`

## Requirements
- R1: The port drives neither line, and raises no interrupt, unless the enable bit (control bit 0) is 1 and the mode field (control bits 7:4) holds 4'b0110 or 4'b1110. Any other mode code is reserved and leaves the port idle.
- R2: After START, the port acknowledges the address byte only when its upper seven bits equal the own-address register (host address 2, bits 6:0). Bit 0 of the address byte selects the direction (1 = the master reads), and status bit 1 reports it. A mismatch gets no acknowledge and no interrupt.
- R3: In write direction, each byte is acknowledged and loaded into the data buffer (host address 0), and the buffer-full status bit (status bit 0, host address 3) is set. A host read of the data buffer clears buffer-full.
- R4: A byte that completes while buffer-full is set is not acknowledged and does not replace the buffer contents. It sets the overflow flag (control bit 2). The flag stays set until the host writes 0 to that bit. Writing 1 leaves it unchanged.
- R5: After the acknowledge clock of each handled byte, the release bit (control bit 1) reads 0, status bit 2 reads 1, and SCL stays pulled low. SCL is freed two cycles after the host writes the release bit to 1.
- R6: In read direction, the byte held in the buffer at release time is sent MSB first.
- R7: A host write to the data buffer while a byte is shifting out is dropped and sets the write-collision flag (control bit 3). The flag stays set until the host writes 0 to that bit.
- R8: The write-collision flag is never set while receiving, and the overflow flag is never set while transmitting.
- R9: When the master does not acknowledge a transmitted byte, the port frees SDA, stops stretching and ignores further clocks until the next START.
- R10: The interrupt output is a single-cycle pulse, raised once for each handled byte.
- R11: With mode 4'b1110, START and STOP each raise one interrupt pulse. With mode 4'b0110 they raise none.
- R12: Both inputs pass a two-flop synchronizer and a filter. A level shorter than the filter length (4 cycles by default) is ignored, so a short low pulse on SDA while SCL is high is not a START.
- R13: After reset, every host register reads 0, both pull-low outputs are 0 and the interrupt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (clears buffer-full when reading the buffer) |
| h_addr | input | 2 | Register select: 0 buffer, 1 control, 2 own address, 3 status |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational from the selected register |
| irq | output | 1 | One-cycle interrupt pulse |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |

## Verification
Register effects show at the read port one clock after a write. A freed SCL appears two clocks after the release write, so the bench waits two falling clock edges before it samples. Bus-side results lag each SCL edge by the synchronizer, filter, edge-detect and FSM registers, about eight clocks in total. The interrupt pulse comes one clock after that. The bench holds each SCL phase for 40 clocks and samples acknowledge and data bits in the middle of the high phase. It counts interrupt pulses only after the falling edge that ends the acknowledge clock has settled. A reference model in the bench tracks whether the port may be active. On every clock, the model is compared with both pull-low outputs and with the interrupt pulse width.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam logic [3:0] MODE_7B    = 4'b0110;
    localparam logic [3:0] MODE_7B_EV = 4'b1110;

    localparam logic [1:0] HA_DATA = 2'd0;
    localparam logic [1:0] HA_CTRL = 2'd1;
    localparam logic [1:0] HA_OWN  = 2'd2;
    localparam logic [1:0] HA_STAT = 2'd3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_HOLD_R,
        ST_HOLD_T,
        ST_TX,
        ST_TX_ACK
    } eng_state_t;

    // control register layout, MSB first
    typedef struct packed {
        logic [3:0] mode;
        logic       wcol;
        logic       ovf;
        logic       rel;
        logic       en;
    } ctrl_t;

    // filtered bus view with detected events
    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_ev_t;

    // engine to register-file pulses
    typedef struct packed {
        logic       load;
        logic       ovf;
        logic       hold;
        logic       byte_done;
        logic [7:0] data;
    } eng_ev_t;

    function automatic logic mode_ok(input logic [3:0] m);
        return (m == MODE_7B) || (m == MODE_7B_EV);
    endfunction

    function automatic logic mode_events(input logic [3:0] m);
        return m == MODE_7B_EV;
    endfunction

endpackage

// File: rtl/i2cs_filt.sv
module i2cs_filt #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int FW = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sq;
    logic [FW-1:0]          cnt;
    logic                   synced;

    assign synced = sq[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sq     <= '1;
            cnt    <= '0;
            line_o <= 1'b1;
        end else begin
            sq <= {sq[SYNC_STAGES-2:0], line_i};
            if (synced == line_o) begin
                cnt <= '0;
            end else if (cnt == FW'(FILT_CYC - 1)) begin
                cnt    <= '0;
                line_o <= synced;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // a change of the filtered level needs the synchronized level to disagree first
    AST_FILT_AGREE: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_o) |-> $past(synced) != $past(line_o)); // R12

endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        ev.scl      = scl_f;
        ev.sda      = sda_f;
        ev.start    = scl_f && scl_p && sda_p && !sda_f;
        ev.stop     = scl_f && scl_p && !sda_p && sda_f;
        ev.scl_rise = scl_f && !scl_p;
        ev.scl_fall = !scl_f && scl_p;
    end

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  bus_ev_t    ev,
    input  logic [6:0] own_addr,
    input  logic       rel,
    input  logic       bf,
    input  logic [7:0] tx_byte,
    output eng_ev_t    eng_o,
    output logic       sda_drv_o,
    output logic       hold_o,
    output logic       rd_dir_o,
    output logic       tx_busy_o
);
    eng_state_t st;
    logic [3:0] cnt;
    logic [7:0] sh;
    logic       mack;

    assign hold_o    = (st == ST_HOLD_R) || (st == ST_HOLD_T);
    assign tx_busy_o = (st == ST_TX) || (st == ST_TX_ACK);

    always_ff @(posedge clk) begin
        eng_o.load      <= 1'b0;
        eng_o.ovf       <= 1'b0;
        eng_o.hold      <= 1'b0;
        eng_o.byte_done <= 1'b0;
        if (rst || !active) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            sh         <= '0;
            mack       <= 1'b0;
            sda_drv_o  <= 1'b0;
            rd_dir_o   <= 1'b0;
            eng_o.data <= '0;
        end else if (ev.start) begin
            st        <= ST_ADDR;
            cnt       <= '0;
            sda_drv_o <= 1'b0;
        end else if (ev.stop) begin
            st        <= ST_IDLE;
            sda_drv_o <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_ADDR, ST_RX: begin
                    if (ev.scl_rise && cnt != 4'd8) begin
                        sh  <= {sh[6:0], ev.sda};
                        cnt <= cnt + 1'b1;
                    end else if (ev.scl_fall && cnt == 4'd8) begin
                        if (st == ST_ADDR) begin
                            if (sh[7:1] == own_addr) begin
                                sda_drv_o <= 1'b1;
                                rd_dir_o  <= sh[0];
                                st        <= ST_ADR_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            if (bf) begin
                                eng_o.ovf <= 1'b1;
                            end else begin
                                eng_o.load <= 1'b1;
                                eng_o.data <= sh;
                                sda_drv_o  <= 1'b1;
                            end
                            st <= ST_RX_ACK;
                        end
                    end
                end
                ST_ADR_ACK, ST_RX_ACK: begin
                    if (ev.scl_fall) begin
                        sda_drv_o       <= 1'b0;
                        eng_o.byte_done <= 1'b1;
                        eng_o.hold      <= 1'b1;
                        st <= (st == ST_ADR_ACK && rd_dir_o) ? ST_HOLD_T : ST_HOLD_R;
                    end
                end
                ST_HOLD_R: begin
                    if (rel && !eng_o.hold) begin
                        cnt <= '0;
                        st  <= ST_RX;
                    end
                end
                ST_HOLD_T: begin
                    if (rel && !eng_o.hold) begin
                        sh        <= tx_byte;
                        sda_drv_o <= !tx_byte[7];
                        cnt       <= '0;
                        st        <= ST_TX;
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_drv_o <= 1'b0;
                            st        <= ST_TX_ACK;
                        end else begin
                            cnt       <= cnt + 1'b1;
                            sh        <= {sh[6:0], 1'b0};
                            sda_drv_o <= !sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_rise) begin
                        mack <= !ev.sda;
                    end else if (ev.scl_fall) begin
                        eng_o.byte_done <= 1'b1;
                        if (mack) begin
                            eng_o.hold <= 1'b1;
                            st         <= ST_HOLD_T;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // the port starts pulling SDA only while SCL is low
    AST_SDA_SETUP: assert property (@(posedge clk) disable iff (rst || !active)
        $rose(sda_drv_o) |-> !ev.scl); // R6

    // a stretched clock stays stretched until software releases it
    AST_STRETCH_KEEP: assert property (@(posedge clk) disable iff (rst || !active)
        hold_o && !rel |=> hold_o); // R5

    // a master NACK leaves the bus free
    AST_NACK_FREE: assert property (@(posedge clk) disable iff (rst || !active)
        (st == ST_TX_ACK) && ev.scl_fall && !mack && !ev.start && !ev.stop
            |=> !sda_drv_o && !hold_o); // R9

endmodule

// File: rtl/i2cs_port.sv
module i2cs_port
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       h_wr,
    input  logic       h_rd,
    input  logic [1:0] h_addr,
    input  logic [7:0] h_wdata,
    output logic [7:0] h_rdata,
    output logic       irq,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_pull,
    output logic       sda_pull
);
    localparam int NLINES = 2;

    ctrl_t      ctrl_q;
    logic [7:0] buf_q;
    logic [6:0] own_q;
    logic       bf_q;
    logic       irq_q;

    logic [NLINES-1:0] raw_lines, filt_lines;
    bus_ev_t ev;
    eng_ev_t eng;
    logic    active, eng_sda, eng_hold, eng_rd, tx_busy;
    logic    wr_data, wr_ctrl;

    assign raw_lines = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2cs_filt #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYC   (FILT_CYC)
        ) u_filt (
            .clk   (clk),
            .rst   (rst),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
        );
    end

    i2cs_cond u_cond (
        .clk  (clk),
        .rst  (rst),
        .scl_f(filt_lines[0]),
        .sda_f(filt_lines[1]),
        .ev   (ev)
    );

    assign active = ctrl_q.en && mode_ok(ctrl_q.mode);

    i2cs_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .ev       (ev),
        .own_addr (own_q),
        .rel      (ctrl_q.rel),
        .bf       (bf_q),
        .tx_byte  (buf_q),
        .eng_o    (eng),
        .sda_drv_o(eng_sda),
        .hold_o   (eng_hold),
        .rd_dir_o (eng_rd),
        .tx_busy_o(tx_busy)
    );

    assign wr_data = h_wr && (h_addr == HA_DATA);
    assign wr_ctrl = h_wr && (h_addr == HA_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            buf_q  <= '0;
            own_q  <= '0;
            bf_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.mode <= h_wdata[7:4];
                ctrl_q.wcol <= ctrl_q.wcol & h_wdata[3];
                ctrl_q.ovf  <= ctrl_q.ovf & h_wdata[2];
                ctrl_q.rel  <= h_wdata[1];
                ctrl_q.en   <= h_wdata[0];
            end
            if (eng.hold) ctrl_q.rel <= 1'b0;
            if (eng.ovf) ctrl_q.ovf <= 1'b1;
            if (wr_data && tx_busy) ctrl_q.wcol <= 1'b1;

            if (eng.load) begin
                buf_q <= eng.data;
            end else if (wr_data && !tx_busy) begin
                buf_q <= h_wdata;
            end

            if (eng.load) begin
                bf_q <= 1'b1;
            end else if (h_rd && h_addr == HA_DATA) begin
                bf_q <= 1'b0;
            end

            if (h_wr && h_addr == HA_OWN) own_q <= h_wdata[6:0];

            irq_q <= active && (eng.byte_done ||
                     (mode_events(ctrl_q.mode) && (ev.start || ev.stop)));
        end
    end

    always_comb begin
        unique case (h_addr)
            HA_DATA: h_rdata = buf_q;
            HA_CTRL: h_rdata = ctrl_q;
            HA_OWN:  h_rdata = {1'b0, own_q};
            default: h_rdata = {5'd0, active && eng_hold, eng_rd, bf_q};
        endcase
    end

    assign irq      = irq_q;
    assign scl_pull = active && eng_hold;
    assign sda_pull = active && eng_sda;

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !active |=> !eng_hold && !eng_sda); // R1

    AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (rst)
        eng.load |-> !bf_q); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        eng.ovf |-> bf_q); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.ovf && !(wr_ctrl && !h_wdata[2]) |=> ctrl_q.ovf); // R4

    AST_REL_CLEARED: assert property (@(posedge clk) disable iff (rst)
        eng.hold |=> !ctrl_q.rel); // R5

    AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.wcol && !(wr_ctrl && !h_wdata[3]) |=> ctrl_q.wcol); // R7

    AST_WCOL_TX_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.wcol) |-> $past(tx_busy)); // R8

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q); // R10

endmodule

// File: tb/i2cs_port_bench.sv
module i2cs_port_bench;
    localparam int HALF = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_wr = 1'b0, h_rd = 1'b0;
    logic [1:0] h_addr = 2'd0;
    logic [7:0] h_wdata = 8'd0;
    logic [7:0] h_rdata;
    logic       irq, scl_pull, sda_pull;
    logic       m_scl_lo = 1'b0, m_sda_lo = 1'b0;
    wire        scl_bus = !(m_scl_lo || scl_pull);
    wire        sda_bus = !(m_sda_lo || sda_pull);

    int total = 0, bad = 0;
    int irq_cnt = 0, width_bad = 0, mon_bad = 0;
    bit irq_prev = 1'b0, sda_seen = 1'b0, scl_seen = 1'b0;
    bit model_active = 1'b0;

    always #5 clk = ~clk;

    i2cs_port u_i2cs_port (
        .clk(clk), .rst(rst), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .irq(irq),
        .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (!rst) begin
            if (irq) irq_cnt++;
            if (irq && irq_prev) width_bad++;
            irq_prev = irq;
            if (!model_active && (scl_pull || sda_pull || irq)) mon_bad++;
            if (sda_pull) sda_seen = 1'b1;
            if (scl_pull) scl_seen = 1'b1;
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        h_addr = a; h_wdata = d; h_wr = 1'b1;
        @(posedge clk); #1;
        h_wr = 1'b0;
        if (a == 2'd1) model_active = d[0] && (d[7:4] == 4'b0110 || d[7:4] == 4'b1110);
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        h_addr = a; h_rd = 1'b1;
        #1 d = h_rdata;
        @(posedge clk); #1;
        h_rd = 1'b0;
    endtask

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_lo = 1'b0;
        while (!scl_bus) @(negedge clk);
        half();
    endtask

    task automatic i2c_start();
        m_sda_lo = 1'b1; half();
        m_scl_lo = 1'b1; half();
    endtask

    task automatic i2c_stop();
        m_sda_lo = 1'b1; half();
        scl_up();
        m_sda_lo = 1'b0; half();
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_lo = !b[i]; half();
            scl_up();
            m_scl_lo = 1'b1; half();
        end
        m_sda_lo = 1'b0; half();
        scl_up();
        ack = !sda_bus;
        m_scl_lo = 1'b1; half();
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] b);
        m_sda_lo = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            half();
            scl_up();
            b[i] = sda_bus;
            m_scl_lo = 1'b1;
        end
        half();
        m_sda_lo = give_ack; half();
        scl_up();
        m_scl_lo = 1'b1; half();
        m_sda_lo = 1'b0; half();
    endtask

    initial begin
        logic [7:0] d;
        bit ack;
        int ic;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        host_rd(2'd0, d); check("R13 data after reset", d, 8'h00);
        host_rd(2'd1, d); check("R13 control after reset", d, 8'h00);
        host_rd(2'd2, d); check("R13 own addr after reset", d, 8'h00);
        host_rd(2'd3, d); check("R13 status after reset", d, 8'h00);
        check("R13 pulls after reset", {scl_pull, sda_pull, irq}, 0);

        host_wr(2'd2, 8'h3A);
        // R1 disabled port ignores its address
        ic = irq_cnt;
        i2c_start(); wbyte(8'h74, ack); i2c_stop();
        check("R1 no ack while disabled", ack, 0);
        // R1 reserved mode code stays idle
        host_wr(2'd1, 8'h81);
        i2c_start(); wbyte(8'h74, ack); i2c_stop();
        check("R1 no ack in reserved mode", ack, 0);
        check("R1 no irq while inactive", irq_cnt - ic, 0);

        host_wr(2'd1, 8'h61);
        // R11 no start irq in plain mode; R2 mismatch
        ic = irq_cnt;
        i2c_start();
        check("R11 no start irq in mode 0110", irq_cnt - ic, 0);
        wbyte(8'h50, ack);
        check("R2 mismatch not acked", ack, 0);
        check("R2 mismatch no irq", irq_cnt - ic, 0);
        i2c_stop();
        check("R11 no stop irq in mode 0110", irq_cnt - ic, 0);

        // R2 match, R5 stretch, R3 receive, R4 overflow
        ic = irq_cnt;
        i2c_start(); wbyte(8'h74, ack);
        check("R2 match acked", ack, 1);
        check("R10 one irq for address", irq_cnt - ic, 1);
        check("R5 scl held after byte", scl_pull, 1);
        host_rd(2'd1, d); check("R5 release bit cleared", d[1], 0);
        host_rd(2'd3, d); check("R5 status held, R2 write dir", d[2:1], 2'b10);
        repeat (100) @(negedge clk);
        check("R5 scl still held", scl_pull, 1);
        host_wr(2'd1, 8'h6F);
        repeat (2) @(negedge clk);
        check("R5 scl freed after release", scl_pull, 0);
        wbyte(8'hC5, ack);
        check("R3 data byte acked", ack, 1);
        check("R10 irq per byte", irq_cnt - ic, 2);
        host_rd(2'd3, d); check("R3 buffer full set", d[0], 1);
        host_wr(2'd1, 8'h6F);
        wbyte(8'h11, ack);
        check("R4 overflow byte not acked", ack, 0);
        host_rd(2'd1, d); check("R4 overflow flag set", d[2], 1);
        host_wr(2'd1, 8'h6F);
        i2c_stop();
        host_rd(2'd0, d); check("R4 buffer keeps first byte (R3 data)", d, 8'hC5);
        host_rd(2'd3, d); check("R3 read clears buffer full", d[0], 0);
        host_rd(2'd1, d); check("R4 overflow flag sticky", d[2], 1);
        host_wr(2'd1, 8'h61);
        host_rd(2'd1, d); check("R4 overflow flag cleared by 0", d, 8'h61);

        // R8 buffer write in receive direction is no collision
        i2c_start(); wbyte(8'h74, ack);
        host_wr(2'd1, 8'h6F);
        wbyte(8'h3C, ack);
        host_rd(2'd0, d); check("R3 second byte", d, 8'h3C);
        host_wr(2'd0, 8'h99);
        host_rd(2'd1, d); check("R8 no collision while receiving", d[3], 0);
        host_wr(2'd1, 8'h6F);
        i2c_stop();
        // leave buffer full before the read transfer
        i2c_start(); wbyte(8'h74, ack);
        host_wr(2'd1, 8'h6F);
        wbyte(8'h42, ack);
        host_wr(2'd1, 8'h6F);
        i2c_stop();

        // R6 read, R7 collision, R9 nack
        ic = irq_cnt;
        i2c_start(); wbyte(8'h75, ack);
        check("R2 read address acked", ack, 1);
        host_rd(2'd3, d); check("R2 read direction status", d[1], 1);
        host_wr(2'd0, 8'hB6);
        host_rd(2'd1, d); check("R7 no collision while held", d[3], 0);
        host_wr(2'd1, 8'h6F);
        repeat (3) @(negedge clk);
        host_wr(2'd0, 8'h00);
        host_rd(2'd1, d); check("R7 collision flag set", d[3], 1);
        host_rd(2'd0, d); check("R7 colliding write dropped", d, 8'hB6);
        rbyte(1'b1, d);
        check("R6 first byte MSB first", d, 8'hB6);
        check("R10 irq count read", irq_cnt - ic, 2);
        host_wr(2'd0, 8'h3C);
        host_wr(2'd1, 8'h6F);
        rbyte(1'b0, d);
        check("R6 second byte", d, 8'h3C);
        sda_seen = 1'b0; scl_seen = 1'b0;
        ic = irq_cnt;
        rbyte(1'b0, d);
        check("R9 bus free after nack", {sda_seen, scl_seen}, 0);
        check("R9 idle byte reads ones", d, 8'hFF);
        check("R9 no irq after nack", irq_cnt - ic, 0);
        i2c_stop();
        host_rd(2'd1, d);
        check("R8 no overflow while transmitting", d[2], 0);
        check("R7 collision flag sticky", d[3], 1);
        host_wr(2'd1, 8'h61);
        host_rd(2'd1, d); check("R7 collision cleared by 0", d, 8'h61);

        // R11 event mode
        host_wr(2'd1, 8'hE1);
        ic = irq_cnt;
        i2c_start();
        check("R11 start irq", irq_cnt - ic, 1);
        i2c_stop();
        check("R11 stop irq", irq_cnt - ic, 2);

        // R12 glitch filter
        ic = irq_cnt;
        m_sda_lo = 1'b1; repeat (2) @(negedge clk);
        m_sda_lo = 1'b0; repeat (30) @(negedge clk);
        check("R12 short sda pulse ignored", irq_cnt - ic, 0);
        m_sda_lo = 1'b1; repeat (30) @(negedge clk);
        check("R12 long pulse is a start", irq_cnt - ic, 1);
        m_sda_lo = 1'b0; repeat (30) @(negedge clk);
        check("R11 release is a stop", irq_cnt - ic, 2);

        check("R1 per-clock model mismatches", mon_bad, 0);
        check("R10 irq pulse width", width_bad, 0);
        summary();
    end

endmodule